// File: doc/BRIEF.md
# Strobed Serial Register Slave

A small register file that a host reaches over four slow lines: a serial clock, a data line into the block, a data line out of the block, and an active-low strobe. There is no chip select. Every rising serial-clock edge taken while the strobe is high moves the input bit into a 40-bit shift register. A serial-clock pulse given while the strobe is low commits a command. The level on the input data line during that pulse selects the command: high means write, low means read.

A write shifts the 32-bit value first and the 8-bit address after it. A read shifts only the address, commits, and then clocks 32 result bits out. The bank holds a mode word, a multiplexer word, a DIP-switch input word, a reset-control word and a fixed version word. A write with bit 0 set to the reset-control word raises a one-cycle reset request. All serial lines are asynchronous to the system clock and are resynchronised before use.

Top module: `strobed_reg_slave`

## Requirements
- R1: After rst_ni is released, mode_o and mux_o are zero, and reset_req_o and sdo_o are low.
- R2: Bits are shifted most significant bit first. They are sampled on rising sck_i edges while stb_ni is high. A strobed pulse with sdi_i high takes the last 40 bits: bits 39..8 are the data and bits 7..0 are the address. A write to address 0x00 sets mode_o.
- R3: A write to address 0x02 sets mux_o.
- R4: A strobed pulse with sdi_i low loads the register addressed by the last 8 shifted bits. After the falling edge of that pulse, sdo_o shows bit 31, and each later falling sck_i edge presents the next lower bit. Addresses 0x00 and 0x02 read back mode_o and mux_o.
- R5: Address 0xFF reads the VERSION parameter, which defaults to 0xA5C30102.
- R6: Address 0x08 reads dip_i, zero-extended and taken through a two-flop synchroniser.
- R7: Writes to the read-only addresses 0x08 and 0xFF, and to unmapped addresses, have no effect on mode_o, mux_o, reset_req_o or any readback.
- R8: Reads of unmapped addresses return zero.
- R9: A write to address 0x80 with bit 0 set drives reset_req_o high for exactly one system clock. It stores bits 31..1, and bit 0 then reads back as 0.
- R10: A write to address 0x80 with bit 0 clear stores bits 31..1 and gives no reset request.
- R11: Only the last 40 bits shifted before a commit count; earlier bits are discarded.
- R12: Shifting with the strobe high changes no register output, and sdo_o changes only after a falling sck_i edge or a read commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial clock from the host, idles low |
| stb_ni | input | 1 | Active-low command strobe, idles high |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| dip_i | input | DIP_W | DIP switch levels |
| mode_o | output | 32 | Mode word |
| mux_o | output | 32 | Multiplexer word |
| reset_req_o | output | 1 | One-cycle board reset request |

## Verification
The hardest case to reach from the ports is the reset-control write. It must give a single-cycle pulse and also leave a stored word with bit 0 cleared, so the pulse is only visible by watching every system clock. The bench counts the cycles reset_req_o is high after each reset-control write and then reads the word back to see the cleared bit. It also prefixes a write frame with extra junk bits, so a commit that used anything but the last 40 bits would corrupt the multiplexer word.

// File: rtl/srs_pkg.sv
package srs_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned FRAME_W = ADDR_W + DATA_W;

  localparam logic [ADDR_W-1:0] A_MODE    = 8'h00;
  localparam logic [ADDR_W-1:0] A_MUX     = 8'h02;
  localparam logic [ADDR_W-1:0] A_DIP     = 8'h08;
  localparam logic [ADDR_W-1:0] A_RST_CTL = 8'h80;
  localparam logic [ADDR_W-1:0] A_VERSION = 8'hFF;

  typedef struct packed {
    logic                 wr;
    logic                 rd;
    logic [ADDR_W-1:0]    addr;
    logic [DATA_W-1:0]    wdata;
  } cmd_t;
endpackage

// File: rtl/srs_sync.sv
module srs_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/srs_shift_in.sv
module srs_shift_in
  import srs_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_rise_i,
  input  logic stb_n_i,
  input  logic sdi_i,
  output cmd_t cmd_o
);
  logic [FRAME_W-1:0] sr_q;
  cmd_t               cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q  <= '0;
      cmd_q <= '0;
    end else begin
      cmd_q.wr <= 1'b0;
      cmd_q.rd <= 1'b0;
      if (sck_rise_i) begin
        if (stb_n_i) begin
          sr_q <= {sr_q[FRAME_W-2:0], sdi_i};
        end else begin
          // strobed pulse: data line picks the command
          cmd_q.wr    <= sdi_i;
          cmd_q.rd    <= ~sdi_i;
          cmd_q.addr  <= sr_q[ADDR_W-1:0];
          cmd_q.wdata <= sr_q[FRAME_W-1:ADDR_W];
        end
      end
    end
  end

  assign cmd_o = cmd_q;
endmodule

// File: rtl/srs_reg_bank.sv
module srs_reg_bank
  import srs_pkg::*;
#(
  parameter int unsigned DIP_W = 8,
  parameter logic [DATA_W-1:0] VERSION = 32'hA5C3_0102
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  cmd_t              cmd_i,
  input  logic [DIP_W-1:0]  dip_i,
  output logic [DATA_W-1:0] mode_o,
  output logic [DATA_W-1:0] mux_o,
  output logic              reset_req_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int unsigned PAD_W = DATA_W - DIP_W;

  logic [DATA_W-1:0] mode_q, mux_q, rst_ctl_q;
  logic              req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q    <= '0;
      mux_q     <= '0;
      rst_ctl_q <= '0;
      req_q     <= 1'b0;
    end else begin
      req_q <= 1'b0;
      if (cmd_i.wr) begin
        unique case (cmd_i.addr)
          A_MODE:    mode_q <= cmd_i.wdata;
          A_MUX:     mux_q  <= cmd_i.wdata;
          A_RST_CTL: begin
            // bit 0 self-clears so the request fires once
            rst_ctl_q <= {cmd_i.wdata[DATA_W-1:1], 1'b0};
            req_q     <= cmd_i.wdata[0];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    unique case (cmd_i.addr)
      A_MODE:    rdata_o = mode_q;
      A_MUX:     rdata_o = mux_q;
      A_DIP:     rdata_o = {{PAD_W{1'b0}}, dip_i};
      A_RST_CTL: rdata_o = rst_ctl_q;
      A_VERSION: rdata_o = VERSION;
      default:   rdata_o = '0;
    endcase
  end

  assign mode_o      = mode_q;
  assign mux_o       = mux_q;
  assign reset_req_o = req_q;
endmodule

// File: rtl/srs_shift_out.sv
module srs_shift_out #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] ldata_i,
  input  logic              sck_fall_i,
  output logic              sdo_o
);
  logic [DATA_W-1:0] sr_q;
  logic              hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q   <= '0;
      hold_q <= 1'b0;
    end else if (load_i) begin
      sr_q   <= ldata_i;
      hold_q <= 1'b1;
    end else if (sck_fall_i) begin
      // the commit pulse's own falling edge keeps the MSB on the line
      if (hold_q) hold_q <= 1'b0;
      else        sr_q   <= {sr_q[DATA_W-2:0], 1'b0};
    end
  end

  assign sdo_o = sr_q[DATA_W-1];
endmodule

// File: rtl/strobed_reg_slave.sv
module strobed_reg_slave
  import srs_pkg::*;
#(
  parameter int unsigned DIP_W = 8,
  parameter logic [31:0] VERSION = 32'hA5C3_0102
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sck_i,
  input  logic             stb_ni,
  input  logic             sdi_i,
  output logic             sdo_o,
  input  logic [DIP_W-1:0] dip_i,
  output logic [31:0]      mode_o,
  output logic [31:0]      mux_o,
  output logic             reset_req_o
);
  logic             sck_s, stb_s, sdi_s, sck_d;
  logic             sck_rise, sck_fall;
  logic [DIP_W-1:0] dip_s;
  logic [31:0]      rdata;
  cmd_t             cmd;

  srs_sync #(.W(3), .RST_VAL(3'b010)) u_line_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, stb_ni, sdi_i}),
    .q_o   ({sck_s, stb_s, sdi_s})
  );

  srs_sync #(.W(DIP_W)) u_dip_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dip_i),
    .q_o   (dip_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  assign sck_rise = sck_s & ~sck_d;
  assign sck_fall = ~sck_s & sck_d;

  srs_shift_in u_in (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_rise_i(sck_rise),
    .stb_n_i   (stb_s),
    .sdi_i     (sdi_s),
    .cmd_o     (cmd)
  );

  srs_reg_bank #(.DIP_W(DIP_W), .VERSION(VERSION)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_i      (cmd),
    .dip_i      (dip_s),
    .mode_o     (mode_o),
    .mux_o      (mux_o),
    .reset_req_o(reset_req_o),
    .rdata_o    (rdata)
  );

  srs_shift_out #(.DATA_W(DATA_W)) u_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (cmd.rd),
    .ldata_i   (rdata),
    .sck_fall_i(sck_fall),
    .sdo_o     (sdo_o)
  );
endmodule

// File: rtl/strobed_reg_slave_chk.sv
module strobed_reg_slave_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        wr_i,
  input logic        rd_i,
  input logic        sck_fall_i,
  input logic        sdo_i,
  input logic [31:0] mode_i,
  input logic [31:0] mux_i,
  input logic        reset_req_i
);
  // R9
  req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |=> !reset_req_i);

  // R9
  req_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_req_i |-> $past(wr_i));

  // R12
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mode_i) |-> $past(wr_i));

  // R12
  mux_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mux_i) |-> $past(wr_i));

  // R4
  sdo_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_i) |-> $past(sck_fall_i || rd_i));
endmodule

bind strobed_reg_slave strobed_reg_slave_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_i       (cmd.wr),
  .rd_i       (cmd.rd),
  .sck_fall_i (sck_fall),
  .sdo_i      (sdo_o),
  .mode_i     (mode_o),
  .mux_i      (mux_o),
  .reset_req_i(reset_req_o)
);

// File: tb/strobed_reg_slave_test.sv
module strobed_reg_slave_test;
  localparam int CLK_P = 10;
  localparam int HP = 6;
  localparam logic [31:0] VER = 32'hA5C3_0102;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, stb_n = 1'b1, sdi = 1'b0;
  logic sdo, reset_req;
  logic [7:0] dip = 8'h00;
  logic [31:0] mode, mux;
  int total = 0, bad = 0, req_cnt = 0;

  always #(CLK_P/2) clk = ~clk;

  strobed_reg_slave uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .stb_ni(stb_n), .sdi_i(sdi),
    .sdo_o(sdo), .dip_i(dip), .mode_o(mode), .mux_o(mux), .reset_req_o(reset_req)
  );

  always @(posedge clk) if (reset_req) req_cnt <= req_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse;
    sck = 1'b1; wait_clk(HP);
    sck = 1'b0; wait_clk(HP);
  endtask

  task automatic shift_bits(input logic [47:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = v[i];
      wait_clk(HP);
      pulse();
    end
  endtask

  task automatic commit(input logic op);
    stb_n = 1'b0; sdi = op; wait_clk(HP);
    pulse();
    stb_n = 1'b1; sdi = 1'b0; wait_clk(HP);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    shift_bits({8'h00, d, a}, 40);
    commit(1'b1);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    shift_bits({40'h0, a}, 8);
    commit(1'b0);
    d = '0;
    for (int i = 0; i < 32; i++) begin
      d = {d[30:0], sdo};
      pulse();
    end
  endtask

  task automatic t_reset;
    check("R1 mode", mode, 32'h0);
    check("R1 mux", mux, 32'h0);
    check("R1 req", {31'h0, reset_req}, 32'h0);
    check("R1 sdo", {31'h0, sdo}, 32'h0);
  endtask

  task automatic t_rw;
    logic [31:0] d;
    wr(8'h00, 32'h1234_5678);
    check("R2 mode_o", mode, 32'h1234_5678);
    wr(8'h02, 32'h8000_0001);
    check("R3 mux_o", mux, 32'h8000_0001);
    check("R12 mode held", mode, 32'h1234_5678);
    rd(8'h00, d); check("R4 read mode", d, 32'h1234_5678);
    rd(8'h02, d); check("R4 read mux", d, 32'h8000_0001);
    rd(8'hFF, d); check("R5 version", d, VER);
  endtask

  task automatic t_dip;
    logic [31:0] d;
    dip = 8'hC5; wait_clk(8);
    rd(8'h08, d); check("R6 dip", d, 32'h0000_00C5);
    dip = 8'h3A; wait_clk(8);
    rd(8'h08, d); check("R6 dip2", d, 32'h0000_003A);
  endtask

  task automatic t_ignore;
    logic [31:0] d;
    wr(8'hFF, 32'hDEAD_BEEF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h01, 32'h0BAD_0BAD);
    check("R7 mode", mode, 32'h1234_5678);
    check("R7 mux", mux, 32'h8000_0001);
    check("R7 no req", req_cnt, 32'd0);
    rd(8'hFF, d); check("R7 version", d, VER);
    rd(8'h01, d); check("R8 unmapped 01", d, 32'h0);
    rd(8'h7F, d); check("R8 unmapped 7F", d, 32'h0);
  endtask

  task automatic t_reset_req;
    logic [31:0] d;
    req_cnt = 0;
    wr(8'h80, 32'h0000_00F1);
    wait_clk(4);
    check("R9 one pulse", req_cnt, 32'd1);
    rd(8'h80, d); check("R9 bit0 clear", d, 32'h0000_00F0);
    wr(8'h80, 32'h5500_0002);
    wait_clk(4);
    check("R10 no pulse", req_cnt, 32'd1);
    rd(8'h80, d); check("R10 stored", d, 32'h5500_0002);
  endtask

  task automatic t_prefix;
    logic [31:0] d;
    shift_bits({8'hFF, 32'hCAFE_F00D, 8'h02}, 48);
    commit(1'b1);
    check("R11 last 40", mux, 32'hCAFE_F00D);
    shift_bits(48'hFFFF_FFFF_FFFF, 20);
    check("R12 shift only", mux, 32'hCAFE_F00D);
    rd(8'h02, d); check("R11 readback", d, 32'hCAFE_F00D);
  endtask

  initial begin
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_rw();
    t_dip();
    t_ignore();
    t_reset_req();
    t_prefix();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule